// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words whose write port and read port run on unrelated clocks. Its depth is a power-of-two parameter between 64 and 8192 words. A producer in the write domain pushes a word on a rising write-clock edge when both of its active-low write strobes are low. A consumer in the read domain pops a word on a rising read-clock edge when both of its active-low read strobes are low. Either strobe of a pair can veto the transfer by itself.

Each side keeps a binary pointer with one extra wrap bit. The pointer is published to the other domain in Gray code through a chain of synchronizing flip-flops. The write domain computes its fill level against the synchronized read pointer and drives the full and almost-full flags from that level. The read domain does the same against the synchronized write pointer and drives the empty and almost-empty flags. All four flags are active low. The two threshold offsets come from a separate offset-register block and are treated as quasi-static.

A popped word is captured in an output register. That register keeps its value until the next pop. An output-enable input gates the register onto the read-data port and is reflected on a valid output.

Top module: `async_fifo_pflag`

## Requirements
- R1: After reset, empty_n and aempty_n are 0, full_n and afull_n are 1, and rd_q_bus reads 0 with oe high.
- R2: A word is stored on a rising wr_clk edge only when wr_en_a_n and wr_en_b_n are both 0; if either is 1, nothing is stored.
- R3: A word is popped on a rising rd_clk edge only when rd_en_a_n and rd_en_b_n are both 0; if either is 1, the output register and the FIFO contents are unchanged.
- R4: Words leave in the order they were written, with their values intact.
- R5: full_n is 0 exactly when DEPTH words are held, as seen in the write domain; writes while full_n is 0 are discarded.
- R6: Reads while empty_n is 0 are discarded and leave the output register unchanged.
- R7: With write-domain fill level L and offset m = afull_ofs, afull_n is 0 when L >= DEPTH-m and 1 when L <= DEPTH-(m+1).
- R8: With read-domain fill level L and offset n = aempty_ofs, aempty_n is 0 when L <= n and 1 when L >= n+1.
- R9: After a write into an empty FIFO, empty_n rises no later than the fourth rising rd_clk edge after that write's wr_clk edge, and the word can then be read.
- R10: While no read happens, the output register keeps the last word read.
- R11: rd_valid follows oe; rd_q_bus carries the output register when oe is 1 and reads 0 when oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_a_n | input | 1 | First write strobe, active low |
| wr_en_b_n | input | 1 | Second write strobe, active low |
| wr_data | input | DATA_W | Word to store |
| afull_ofs | input | log2(DEPTH) | Almost-full offset m |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| rd_en_a_n | input | 1 | First read strobe, active low |
| rd_en_b_n | input | 1 | Second read strobe, active low |
| oe | input | 1 | Output enable for the read data |
| aempty_ofs | input | log2(DEPTH) | Almost-empty offset n |
| rd_q_bus | output | DATA_W | Output register, gated by oe |
| rd_valid | output | 1 | High while oe is high |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The assertions assume that both offsets stay fixed while words move, and that each offset is below DEPTH. They also assume that reset is applied with both clocks running, so that every pointer and synchronizer stage starts from zero. The stimulus sets the offsets before reset is released and never changes them. It drives strobes and data only on falling clock edges, and it checks any flag driven by the opposite domain only after several cycles of both clocks have passed, so that the synchronizers have settled.

// File: rtl/fifo2c_pkg.sv
`timescale 1ns/1ps
package fifo2c_pkg;
   localparam int MIN_DEPTH   = 64;
   localparam int MAX_DEPTH   = 8192;
   localparam int MIN_STAGES  = 2;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fifo2c_sync.sv
`timescale 1ns/1ps
module fifo2c_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fifo2c_wr_ctl.sv
`timescale 1ns/1ps
module fifo2c_wr_ctl #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a_n,
   input  logic          en_b_n,
   input  logic [AW-1:0] ofs,
   input  logic [PW-1:0] rgray_s,
   output logic          fire,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          full_n,
   output logic          afull_n
);
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

   logic [PW-1:0] wbin_q, wbin_nx, wgray_q, rq_bin, cnt_nx, thr;
   logic          full_q, afull_q;

   always_comb begin
      for (int i = 0; i < PW; i++) rq_bin[i] = ^(rgray_s >> i);
      fire    = !en_a_n && !en_b_n && !full_q;
      wbin_nx = wbin_q + PW'(fire);
      cnt_nx  = wbin_nx - rq_bin;
      thr     = FULL_CNT - {1'b0, ofs};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         full_q  <= 1'b0;
         afull_q <= 1'b0;
      end else begin
         wbin_q  <= wbin_nx;
         wgray_q <= wbin_nx ^ (wbin_nx >> 1);
         full_q  <= (cnt_nx == FULL_CNT);
         afull_q <= (cnt_nx >= thr);
      end
   end

   assign waddr   = wbin_q[AW-1:0];
   assign wgray   = wgray_q;
   assign full_n  = !full_q;
   assign afull_n = !afull_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full_q |=> $stable(wbin_q));  // R5
   AST_WR_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (wbin_q - rq_bin) <= FULL_CNT);  // R5
   AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n) full_q |-> afull_q);  // R7
   AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(wgray_q ^ $past(wgray_q)) <= 1);  // R9
endmodule

// File: rtl/fifo2c_rd_ctl.sv
`timescale 1ns/1ps
module fifo2c_rd_ctl #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a_n,
   input  logic          en_b_n,
   input  logic [AW-1:0] ofs,
   input  logic [PW-1:0] wgray_s,
   output logic          fire,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic          empty_n,
   output logic          aempty_n
);
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

   logic [PW-1:0] rbin_q, rbin_nx, rgray_q, wq_bin, cnt_nx;
   logic          empty_q, aempty_q;

   always_comb begin
      for (int i = 0; i < PW; i++) wq_bin[i] = ^(wgray_s >> i);
      fire    = !en_a_n && !en_b_n && !empty_q;
      rbin_nx = rbin_q + PW'(fire);
      cnt_nx  = wq_bin - rbin_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q   <= '0;
         rgray_q  <= '0;
         empty_q  <= 1'b1;
         aempty_q <= 1'b1;
      end else begin
         rbin_q   <= rbin_nx;
         rgray_q  <= rbin_nx ^ (rbin_nx >> 1);
         empty_q  <= (cnt_nx == '0);
         aempty_q <= (cnt_nx <= {1'b0, ofs});
      end
   end

   assign raddr    = rbin_q[AW-1:0];
   assign rgray    = rgray_q;
   assign empty_n  = !empty_q;
   assign aempty_n = !aempty_q;

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) empty_q |=> $stable(rbin_q));  // R6
   AST_RD_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (wq_bin - rbin_q) <= FULL_CNT);  // R4
   AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty_q |-> aempty_q);  // R8
   AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(rgray_q ^ $past(rgray_q)) <= 1);  // R9
endmodule

// File: rtl/async_fifo_pflag.sv
`timescale 1ns/1ps
module async_fifo_pflag
   import fifo2c_pkg::*;
#(
   parameter  int DATA_W      = 9,
   parameter  int DEPTH       = 64,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en_a_n,
   input  logic              wr_en_b_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     afull_ofs,
   output logic              full_n,
   output logic              afull_n,
   input  logic              rd_en_a_n,
   input  logic              rd_en_b_n,
   input  logic              oe,
   input  logic [AW-1:0]     aempty_ofs,
   output logic [DATA_W-1:0] rd_q_bus,
   output logic              rd_valid,
   output logic              empty_n,
   output logic              aempty_n
);
   if (!is_pow2(DEPTH) || DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("async_fifo_pflag: DEPTH must be a power of two in range");
   end
   if (SYNC_STAGES < MIN_STAGES) begin : g_bad_stages
      $error("async_fifo_pflag: SYNC_STAGES must be at least two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("async_fifo_pflag: DATA_W must be positive");
   end

   logic              wr_fire, rd_fire;
   logic [AW-1:0]     waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] rd_q;

   fifo2c_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .en_a_n(wr_en_a_n), .en_b_n(wr_en_b_n),
      .ofs(afull_ofs), .rgray_s(rgray_s), .fire(wr_fire), .waddr(waddr),
      .wgray(wgray), .full_n(full_n), .afull_n(afull_n)
   );

   fifo2c_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .en_a_n(rd_en_a_n), .en_b_n(rd_en_b_n),
      .ofs(aempty_ofs), .wgray_s(wgray_s), .fire(rd_fire), .raddr(raddr),
      .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   fifo2c_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   fifo2c_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   always_ff @(posedge wr_clk) begin
      if (wr_fire) store[waddr] <= wr_data;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_fire) rd_q <= store[raddr];
   end

   assign rd_q_bus = oe ? rd_q : '0;
   assign rd_valid = oe;

   AST_RDQ_HOLD_NO_STROBE: assert property (@(posedge rd_clk) disable iff (!rst_n) (rd_en_a_n || rd_en_b_n) |=> $stable(rd_q));  // R10
   AST_RDQ_HOLD_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n) !empty_n |=> $stable(rd_q));  // R6
endmodule

// File: tb/tb_async_fifo_pflag.sv
`timescale 1ns/1ps
module tb_async_fifo_pflag;
   localparam int DEPTH = 64;
   localparam int DW    = 9;
   localparam int AW    = 6;
   localparam int M_OFS = 5;
   localparam int N_OFS = 3;

   logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic wa_n = 1'b1, wb_n = 1'b1, ra_n = 1'b1, rb_n = 1'b1, oe = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_q_bus;
   logic full_n, afull_n, empty_n, aempty_n, rd_valid;

   always #5 wr_clk = ~wr_clk;
   always #7 rd_clk = ~rd_clk;

   async_fifo_pflag #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en_a_n(wa_n), .wr_en_b_n(wb_n), .wr_data(wr_data),
      .afull_ofs(AW'(M_OFS)), .full_n(full_n), .afull_n(afull_n),
      .rd_en_a_n(ra_n), .rd_en_b_n(rb_n), .oe(oe), .aempty_ofs(AW'(N_OFS)),
      .rd_q_bus(rd_q_bus), .rd_valid(rd_valid), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] model_q[$];
   logic [DW-1:0] last_q = '0;

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37 + 5) & 'h1FF);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic push(input logic [DW-1:0] d, input logic a_n, input logic b_n);
      @(negedge wr_clk);
      wa_n = a_n; wb_n = b_n; wr_data = d;
      @(negedge wr_clk);
      wa_n = 1'b1; wb_n = 1'b1;
      if (!a_n && !b_n && model_q.size() < DEPTH) model_q.push_back(d);
   endtask

   task automatic pop(input logic a_n, input logic b_n, input string req);
      @(negedge rd_clk);
      ra_n = a_n; rb_n = b_n;
      @(negedge rd_clk);
      ra_n = 1'b1; rb_n = 1'b1;
      if (!a_n && !b_n && model_q.size() > 0) last_q = model_q.pop_front();
      chk(req, "rd_q_bus", int'(rd_q_bus), int'(last_q));
   endtask

   task automatic settle();
      repeat (8) @(negedge rd_clk);
      repeat (3) @(negedge wr_clk);
   endtask

   task automatic t_reset();
      chk("R1", "empty_n", int'(empty_n), 0);
      chk("R1", "aempty_n", int'(aempty_n), 0);
      chk("R1", "full_n", int'(full_n), 1);
      chk("R1", "afull_n", int'(afull_n), 1);
      chk("R1", "rd_q_bus", int'(rd_q_bus), 0);
   endtask

   task automatic t_strobes();
      push(9'h055, 1'b0, 1'b1);
      push(9'h0AA, 1'b1, 1'b0);
      settle();
      chk("R2", "empty_n after vetoed writes", int'(empty_n), 0);
      push(9'h1A5, 1'b0, 1'b0);
      settle();
      chk("R2", "empty_n after accepted write", int'(empty_n), 1);
      pop(1'b0, 1'b1, "R3");
      pop(1'b1, 1'b0, "R3");
      chk("R3", "empty_n after vetoed reads", int'(empty_n), 1);
      pop(1'b0, 1'b0, "R4");
      settle();
      chk("R3", "empty_n after accepted read", int'(empty_n), 0);
   endtask

   task automatic t_first_word();
      int waited;
      push(9'h13C, 1'b0, 1'b0);
      waited = 0;
      while (empty_n == 1'b0 && waited < 10) begin
         @(negedge rd_clk);
         waited++;
      end
      chk("R9", "empty_n risen", int'(empty_n), 1);
      chk("R9", "read edges waited within bound", int'(waited <= 3), 1);
      pop(1'b0, 1'b0, "R9");
      settle();
   endtask

   task automatic t_aempty();
      for (int i = 0; i < N_OFS; i++) push(pat(i), 1'b0, 1'b0);
      settle();
      chk("R8", "aempty_n at n words", int'(aempty_n), 0);
      push(pat(N_OFS), 1'b0, 1'b0);
      settle();
      chk("R8", "aempty_n at n+1 words", int'(aempty_n), 1);
      pop(1'b0, 1'b0, "R4");
      settle();
      chk("R8", "aempty_n back at n words", int'(aempty_n), 0);
      for (int i = 0; i < N_OFS; i++) pop(1'b0, 1'b0, "R4");
      settle();
      chk("R6", "empty_n after drain", int'(empty_n), 0);
   endtask

   task automatic t_afull_full();
      logic [DW-1:0] held;
      for (int i = 0; i < DEPTH - M_OFS - 1; i++) push(pat(100 + i), 1'b0, 1'b0);
      settle();
      chk("R7", "afull_n at DEPTH-(m+1)", int'(afull_n), 1);
      push(pat(200), 1'b0, 1'b0);
      settle();
      chk("R7", "afull_n at DEPTH-m", int'(afull_n), 0);
      chk("R5", "full_n below DEPTH", int'(full_n), 1);
      pop(1'b0, 1'b0, "R4");
      settle();
      chk("R7", "afull_n after one read", int'(afull_n), 1);
      while (model_q.size() < DEPTH) push(pat(300 + model_q.size()), 1'b0, 1'b0);
      settle();
      chk("R5", "full_n at DEPTH", int'(full_n), 0);
      chk("R7", "afull_n at DEPTH", int'(afull_n), 0);
      push(9'h0FF, 1'b0, 1'b0);
      settle();
      chk("R5", "full_n after discarded write", int'(full_n), 0);
      for (int i = 0; i < DEPTH; i++) pop(1'b0, 1'b0, "R4");
      settle();
      chk("R5", "empty_n after DEPTH reads", int'(empty_n), 0);
      chk("R5", "full_n after drain", int'(full_n), 1);
      held = rd_q_bus;
      pop(1'b0, 1'b0, "R6");
      chk("R6", "rd_q_bus after read while empty", int'(rd_q_bus), int'(held));
      repeat (5) @(negedge rd_clk);
      chk("R10", "rd_q_bus held while idle", int'(rd_q_bus), int'(held));
   endtask

   task automatic t_oe();
      push(9'h0C3, 1'b0, 1'b0);
      settle();
      pop(1'b0, 1'b0, "R4");
      oe = 1'b0;
      #1;
      chk("R11", "rd_valid with oe low", int'(rd_valid), 0);
      chk("R11", "rd_q_bus with oe low", int'(rd_q_bus), 0);
      oe = 1'b1;
      #1;
      chk("R11", "rd_valid with oe high", int'(rd_valid), 1);
      chk("R11", "rd_q_bus with oe high", int'(rd_q_bus), 'h0C3);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge rd_clk);
      t_reset();
      t_strobes();
      t_first_word();
      t_aempty();
      t_afull_full();
      t_oe();
      report();
      $finish;
   end
endmodule